// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block is the hazard control for a five-stage in-order integer pipeline: fetch, decode with register read, execute, memory, and write-back. It looks at the register fields held in the decode, execute, memory and write-back stages and decides three things. First, where each execute-stage ALU operand comes from. Second, whether the front of the pipe must hold for one cycle while a bubble enters execute. Third, whether a conditional branch resolved in decode redirects fetch and squashes the instruction behind it.

The register file is written in the last stage and read in the second. Because of this, only read-after-write dependences are handled. A load followed at once by a consumer of its result costs exactly one bubble. After that bubble, the loaded value reaches the consumer through the write-back bypass.

Branches test one register against zero, for either equality or inequality, and compute their target in decode. Fetch is predicted not taken. A taken branch therefore costs one squashed slot. The decode-stage zero test cannot use the execute-stage bypass, so a branch whose operand is still being produced in execute waits one cycle. It also waits when that operand is a load in the memory stage. A plain ALU result in the memory stage is steered to the zero test instead.

Top module: `pipe_hz_ctrl`

## Requirements
- R1: An ALU operand select reads 2'b10 (take the memory-stage result) when the memory-stage instruction writes a nonzero register equal to that operand's source. The select reads 2'b00 (register file) when no producer matches.
- R2: An operand select reads 2'b01 (take the write-back-stage result) when the write-back instruction writes a nonzero register equal to the source and the memory stage does not match.
- R3: When both the memory and write-back stages match the same source, the select reads 2'b10. The younger result wins.
- R4: Register 0 never causes a bypass or a hold. A producer whose write enable is low never matches.
- R5: A load in execute that writes a nonzero register read by an enabled decode source raises `pc_hold`, `ifid_hold` and `idex_bubble` together. An execute-stage instruction that is not a load and feeds a non-branch raises none of them.
- R6: A branch in decode whose tested register is written by the execute-stage instruction raises the hold and bubble outputs.
- R7: A branch whose tested register is written by a load in the memory stage holds. A non-load in the memory stage instead raises `br_fwd_mem` without holding.
- R8: A branch with `id_br_ne`=0 is taken when `id_zero`=1. A branch with `id_br_ne`=1 is taken when `id_zero`=0. A taken branch raises `pc_redirect` and `ifid_flush`.
- R9: A branch whose condition fails raises neither `pc_redirect` nor `ifid_flush`. Neither does a non-branch instruction.
- R10: While the hold is raised, `pc_redirect` and `ifid_flush` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used for property checks |
| rst | input | 1 | Synchronous active-high reset, gates property checks |
| id_rs1 | input | AW | Decode first source register; also the branch test register |
| id_rs2 | input | AW | Decode second source register |
| id_rd1_en | input | 1 | Decode instruction reads `id_rs1` |
| id_rd2_en | input | 1 | Decode instruction reads `id_rs2` |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_ne | input | 1 | Branch sense: 0 branch-if-zero, 1 branch-if-nonzero |
| id_zero | input | 1 | Zero-test result of the branch operand |
| ex_rs1 | input | AW | Execute first source register |
| ex_rs2 | input | AW | Execute second source register |
| ex_rd | input | AW | Execute destination register |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rd | input | AW | Memory-stage destination register |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | AW | Write-back destination register |
| wb_we | input | 1 | Write-back instruction writes a register |
| fwd_a | output | 2 | First ALU operand source select |
| fwd_b | output | 2 | Second ALU operand source select |
| br_fwd_mem | output | 1 | Branch zero test uses the memory-stage result |
| pc_hold | output | 1 | Keep the PC this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register this cycle |
| idex_bubble | output | 1 | Load a bubble into the decode/execute register |
| ifid_flush | output | 1 | Squash the instruction fetched behind a taken branch |
| pc_redirect | output | 1 | Load the branch target into the PC |

## Verification
Every output is a function of the current stage fields. A wrong match, priority or enable term shows on the select or hold outputs in the same cycle that the offending fields are applied. The bench holds each pattern for a cycle and samples mid-cycle. A missed hold would let a consumer read a stale register one cycle later. A hold that was not suppressed would show as a redirect and a flush raised in the same cycle as the bubble. The vectors place each producer stage against each consumer field, so that a swapped priority or a dropped register-0 guard changes a visible select value.

// File: rtl/pipe_hz_pkg.sv
package pipe_hz_pkg;
  // operand source encoding for the execute-stage ALU inputs
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } src_sel_e;

  localparam int unsigned NUM_ALU_OPS = 2;
endpackage

// File: rtl/hz_bypass_sel.sv
module hz_bypass_sel
  import pipe_hz_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_we,
  output src_sel_e      sel
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic mem_hit, wb_hit;

  assign mem_hit = mem_we && (mem_rd != ZERO_REG) && (mem_rd == src);
  assign wb_hit  = wb_we  && (wb_rd  != ZERO_REG) && (wb_rd  == src);

  // younger producer first
  always_comb begin
    if (mem_hit)     sel = SRC_MEM;
    else if (wb_hit) sel = SRC_WB;
    else             sel = SRC_RF;
  end
endmodule

// File: rtl/hz_stall_detect.sv
module hz_stall_detect #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_rd1_en,
  input  logic          id_rd2_en,
  input  logic          id_is_branch,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_is_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic          mem_is_load,
  output logic          stall,
  output logic          br_use_mem
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic ex_writes, mem_writes;
  logic ex_hit1, ex_hit2, mem_hit1;
  logic load_use, br_wait;

  assign ex_writes  = ex_we  && (ex_rd  != ZERO_REG);
  assign mem_writes = mem_we && (mem_rd != ZERO_REG);

  assign ex_hit1  = ex_writes  && (ex_rd  == id_rs1);
  assign ex_hit2  = ex_writes  && (ex_rd  == id_rs2);
  assign mem_hit1 = mem_writes && (mem_rd == id_rs1);

  // load result is not ready until the end of the memory stage
  assign load_use = ex_is_load && ((id_rd1_en && ex_hit1) || (id_rd2_en && ex_hit2));

  // decode-stage zero test sees neither the execute result nor a pending load
  assign br_wait = id_is_branch && (ex_hit1 || (mem_hit1 && mem_is_load));

  assign stall      = load_use || br_wait;
  assign br_use_mem = id_is_branch && mem_hit1 && !mem_is_load;
endmodule

// File: rtl/hz_branch_resolve.sv
module hz_branch_resolve (
  input  logic id_is_branch,
  input  logic id_br_ne,
  input  logic id_zero,
  input  logic stall,
  output logic redirect,
  output logic flush
);
  logic cond_met;

  assign cond_met = id_br_ne ? !id_zero : id_zero;

  // a stalled branch re-evaluates next cycle with valid operands
  always_comb begin
    redirect = id_is_branch && cond_met && !stall;
    flush    = redirect;
  end
endmodule

// File: rtl/pipe_hz_ctrl.sv
module pipe_hz_ctrl
  import pipe_hz_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_rd1_en,
  input  logic          id_rd2_en,
  input  logic          id_is_branch,
  input  logic          id_br_ne,
  input  logic          id_zero,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_is_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic          mem_is_load,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_we,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          br_fwd_mem,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          idex_bubble,
  output logic          ifid_flush,
  output logic          pc_redirect
);
  logic [AW-1:0] op_src [NUM_ALU_OPS];
  src_sel_e      op_sel [NUM_ALU_OPS];
  logic          stall;
  logic          redirect, flush;

  assign op_src[0] = ex_rs1;
  assign op_src[1] = ex_rs2;

  for (genvar g = 0; g < NUM_ALU_OPS; g++) begin : g_op
    hz_bypass_sel #(.AW(AW)) u_sel (
      .src    (op_src[g]),
      .mem_rd (mem_rd),
      .mem_we (mem_we),
      .wb_rd  (wb_rd),
      .wb_we  (wb_we),
      .sel    (op_sel[g])
    );
  end

  assign fwd_a = op_sel[0];
  assign fwd_b = op_sel[1];

  hz_stall_detect #(.AW(AW)) u_stall (
    .id_rs1       (id_rs1),
    .id_rs2       (id_rs2),
    .id_rd1_en    (id_rd1_en),
    .id_rd2_en    (id_rd2_en),
    .id_is_branch (id_is_branch),
    .ex_rd        (ex_rd),
    .ex_we        (ex_we),
    .ex_is_load   (ex_is_load),
    .mem_rd       (mem_rd),
    .mem_we       (mem_we),
    .mem_is_load  (mem_is_load),
    .stall        (stall),
    .br_use_mem   (br_fwd_mem)
  );

  hz_branch_resolve u_br (
    .id_is_branch (id_is_branch),
    .id_br_ne     (id_br_ne),
    .id_zero      (id_zero),
    .stall        (stall),
    .redirect     (redirect),
    .flush        (flush)
  );

  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;
  assign ifid_flush  = flush;
  assign pc_redirect = redirect;

  // R3: the memory-stage result wins over write-back for the same source
  p_mem_first_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_rd != '0 && mem_rd == ex_rs1) |-> (fwd_a == 2'b10));

  // R4: register 0 is never bypassed
  p_zero_reg_r4: assert property (@(posedge clk) disable iff (rst)
    (ex_rs2 == '0) |-> (fwd_b == 2'b00));

  // R5: load followed by an enabled consumer inserts a bubble
  p_load_use_r5: assert property (@(posedge clk) disable iff (rst)
    (ex_is_load && ex_we && ex_rd != '0 && id_rd1_en && id_rs1 == ex_rd) |-> idex_bubble);

  // R6: branch operand still in execute forces a hold
  p_br_ex_wait_r6: assert property (@(posedge clk) disable iff (rst)
    (id_is_branch && ex_we && ex_rd != '0 && ex_rd == id_rs1) |-> pc_hold);

  // R10: no redirect while the front end is held
  p_hold_no_redir_r10: assert property (@(posedge clk) disable iff (rst)
    pc_hold |-> (!pc_redirect && !ifid_flush));
endmodule

// File: tb/pipe_hz_ctrl_test.sv
module pipe_hz_ctrl_test;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst;
  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic id_rd1_en, id_rd2_en, id_is_branch, id_br_ne, id_zero;
  logic ex_we, ex_is_load, mem_we, mem_is_load, wb_we;
  logic [1:0] fwd_a, fwd_b;
  logic br_fwd_mem, pc_hold, ifid_hold, idex_bubble, ifid_flush, pc_redirect;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pipe_hz_ctrl #(.AW(AW)) uut (
    .clk(clk), .rst(rst),
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rd1_en(id_rd1_en), .id_rd2_en(id_rd2_en),
    .id_is_branch(id_is_branch), .id_br_ne(id_br_ne), .id_zero(id_zero),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_we(ex_we), .ex_is_load(ex_is_load),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_is_load(mem_is_load),
    .wb_rd(wb_rd), .wb_we(wb_we),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .br_fwd_mem(br_fwd_mem),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
    .ifid_flush(ifid_flush), .pc_redirect(pc_redirect)
  );

  typedef struct packed {
    logic [AW-1:0] rs1;
    logic [AW-1:0] rs2;
    logic [AW-1:0] mrd;
    logic          mwe;
    logic [AW-1:0] wrd;
    logic          wwe;
    logic [1:0]    ea;
    logic [1:0]    eb;
  } fv_t;

  localparam fv_t FV [10] = '{
    '{5'd3,  5'd4,  5'd3,  1'b1, 5'd0,  1'b0, 2'b10, 2'b00}, // R1 operand A from memory stage
    '{5'd5,  5'd6,  5'd6,  1'b1, 5'd9,  1'b1, 2'b00, 2'b10}, // R1 operand B from memory stage
    '{5'd7,  5'd8,  5'd2,  1'b1, 5'd7,  1'b1, 2'b01, 2'b00}, // R2 write-back bypass (post-bubble load)
    '{5'd9,  5'd9,  5'd9,  1'b1, 5'd9,  1'b1, 2'b10, 2'b10}, // R3 both match, younger wins
    '{5'd10, 5'd11, 5'd10, 1'b1, 5'd11, 1'b1, 2'b10, 2'b01}, // R3 split producers
    '{5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00}, // R4 register 0
    '{5'd12, 5'd12, 5'd12, 1'b0, 5'd12, 1'b0, 2'b00, 2'b00}, // R4 write enables low
    '{5'd13, 5'd1,  5'd13, 1'b0, 5'd13, 1'b1, 2'b01, 2'b00}, // R4 memory enable low falls to write-back
    '{5'd14, 5'd14, 5'd15, 1'b1, 5'd14, 1'b1, 2'b01, 2'b01}, // R2 both operands from write-back
    '{5'd16, 5'd17, 5'd18, 1'b1, 5'd19, 1'b1, 2'b00, 2'b00}  // R1 no producer matches
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    id_rs1 = '0; id_rs2 = '0; id_rd1_en = 0; id_rd2_en = 0;
    id_is_branch = 0; id_br_ne = 0; id_zero = 0;
    ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0; ex_we = 0; ex_is_load = 0;
    mem_rd = '0; mem_we = 0; mem_is_load = 0; wb_rd = '0; wb_we = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    #2;
  endtask

  task automatic chk_ctl(input string req, input logic hold, input logic redir, input logic bfm);
    chk(req, {31'd0, pc_hold}, {31'd0, hold});
    chk(req, {31'd0, ifid_hold}, {31'd0, hold});
    chk(req, {31'd0, idex_bubble}, {31'd0, hold});
    chk(req, {31'd0, pc_redirect}, {31'd0, redir});
    chk(req, {31'd0, ifid_flush}, {31'd0, redir});
    chk(req, {31'd0, br_fwd_mem}, {31'd0, bfm});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // reset / idle state: nothing matched, nothing held
    settle();
    chk("R1 idle fwd_a", {30'd0, fwd_a}, 32'd0);
    chk("R1 idle fwd_b", {30'd0, fwd_b}, 32'd0);
    chk_ctl("R9 idle", 0, 0, 0);

    // bypass table
    for (int i = 0; i < 10; i++) begin
      idle();
      ex_rs1 = FV[i].rs1; ex_rs2 = FV[i].rs2;
      mem_rd = FV[i].mrd; mem_we = FV[i].mwe;
      wb_rd  = FV[i].wrd; wb_we  = FV[i].wwe;
      settle();
      chk($sformatf("bypass vector %0d operand A", i), {30'd0, fwd_a}, {30'd0, FV[i].ea});
      chk($sformatf("bypass vector %0d operand B", i), {30'd0, fwd_b}, {30'd0, FV[i].eb});
    end

    // R5: load-use on first source
    idle(); ex_is_load = 1; ex_we = 1; ex_rd = 5'd7; id_rs1 = 5'd7; id_rd1_en = 1;
    settle(); chk_ctl("R5 load-use rs1", 1, 0, 0);

    // R5: load-use on second source
    idle(); ex_is_load = 1; ex_we = 1; ex_rd = 5'd8; id_rs2 = 5'd8; id_rd2_en = 1;
    settle(); chk_ctl("R5 load-use rs2", 1, 0, 0);

    // R5: source not read -> no hold
    idle(); ex_is_load = 1; ex_we = 1; ex_rd = 5'd8; id_rs2 = 5'd8; id_rd2_en = 0;
    settle(); chk_ctl("R5 unread source", 0, 0, 0);

    // R4: load to register 0
    idle(); ex_is_load = 1; ex_we = 1; ex_rd = 5'd0; id_rs1 = 5'd0; id_rd1_en = 1;
    settle(); chk_ctl("R4 load to r0", 0, 0, 0);

    // R5: ALU producer in execute feeding non-branch is bypassed, not held
    idle(); ex_we = 1; ex_rd = 5'd6; id_rs1 = 5'd6; id_rd1_en = 1;
    settle(); chk_ctl("R5 alu no hold", 0, 0, 0);

    // R6 + R10: branch on execute result holds, even with condition true
    idle(); id_is_branch = 1; id_zero = 1; id_rs1 = 5'd4; ex_we = 1; ex_rd = 5'd4;
    settle(); chk_ctl("R6 R10 branch waits on execute", 1, 0, 0);

    // R7: branch on memory-stage load holds
    idle(); id_is_branch = 1; id_zero = 1; id_rs1 = 5'd9; mem_we = 1; mem_is_load = 1; mem_rd = 5'd9;
    settle(); chk_ctl("R7 branch waits on load", 1, 0, 0);

    // R7 + R8: branch on memory-stage ALU result uses that bypass, taken
    idle(); id_is_branch = 1; id_zero = 1; id_rs1 = 5'd9; mem_we = 1; mem_rd = 5'd9;
    settle(); chk_ctl("R7 R8 branch uses memory bypass", 0, 1, 1);

    // R8: branch-if-nonzero taken on nonzero operand
    idle(); id_is_branch = 1; id_br_ne = 1; id_zero = 0; id_rs1 = 5'd3;
    settle(); chk_ctl("R8 bnez taken", 0, 1, 0);

    // R9: branch-if-nonzero falls through on zero
    idle(); id_is_branch = 1; id_br_ne = 1; id_zero = 1; id_rs1 = 5'd3;
    settle(); chk_ctl("R9 bnez not taken", 0, 0, 0);

    // R9: branch-if-zero falls through on nonzero
    idle(); id_is_branch = 1; id_br_ne = 0; id_zero = 0; id_rs1 = 5'd3;
    settle(); chk_ctl("R9 beqz not taken", 0, 0, 0);

    // R9: non-branch ignores zero flag
    idle(); id_zero = 1; id_rs1 = 5'd3; id_rd1_en = 1;
    settle(); chk_ctl("R9 non-branch", 0, 0, 0);

    // R4: branch operand register 0 with execute writing r0
    idle(); id_is_branch = 1; id_zero = 1; id_rs1 = 5'd0; ex_we = 1; ex_rd = 5'd0;
    settle(); chk_ctl("R4 branch on r0", 0, 1, 0);

    idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule